// File: doc/BRIEF.md
# Board-Variant Display Control and Card Status Registers

This block holds two memory-mapped registers whose behaviour depends on a static board-variant code. The display control register sets which of its bits software may change based on that code. On one variant, the two low bits of every write also drive a pixel-format select output. The card status register is read-only. It shows two level inputs, card presence and write protection, after synchronisation. The bit that carries write protection depends on the variant.

The variant code is a strap input that holds steady after reset. Software reads and writes through a simple single-cycle register port: select, write strobe, byte address and 32-bit data. Read data is combinational from the address. The register at byte offset 0x50 is display control, and the one at 0x48 is card status. Every other offset reads as zero.

Top module: `disp_card_regs`

## Requirements
- R1: After reset the display register reads 0x00001F00 (field 12:8 = 0x1F) on variants 0x100, 0x140, 0x178 and 0x182, the format select output is 0, and the card status register reads 0.
- R2: On variant 0x100 a display write keeps bits 13:8 and replaces every other bit with the write data.
- R3: On variant 0x100 each display write loads the format select output from write data bits 1:0, and the output holds its value across all other bus activity.
- R4: On variant 0x140 display writes use the same mask as R2 and leave the format select output unchanged.
- R5: On variants 0x178 and 0x182 a display write changes only bit 7. All other bits keep their value.
- R6: On variant 0x190 and on any code not listed above, the display register reads zero and writes have no visible effect.
- R7: Card status bit 0 follows the card-present input through a two-flop synchroniser. A change is not visible after one clock edge and is visible after the second.
- R8: The synchronised write-protect input appears at card status bit 2 on variants 0x100 and 0x140, and at bit 1 on all other codes. All other status bits read zero.
- R9: Writes to the card status offset change neither card status, the display register nor the format select output.
- R10: Offsets other than 0x48 and 0x50 read zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| board_id | input | 12 | Static board-variant code |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| card_present_i | input | 1 | Asynchronous card-present level |
| wprot_i | input | 1 | Asynchronous write-protect level |
| fmt_mux_o | output | 2 | Pixel-format select |

## Verification
The hardest case to reach is the format select output holding its value while the display register is written under a different mask, or while other offsets are written. These situations need a reset with a new variant code and then a write sequence. The stimulus table therefore groups vectors by variant and issues a reset whenever the code changes. Directed tests then write the card status offset and an unmapped offset after a known select value has been loaded. The synchroniser depth is measured by reading card status one edge and then two edges after an input change.

// File: rtl/disp_card_pkg.sv
package disp_card_pkg;

  localparam int ID_W = 12;

  localparam logic [ID_W-1:0] BID_MUXED  = 12'h100;
  localparam logic [ID_W-1:0] BID_PLAIN  = 12'h140;
  localparam logic [ID_W-1:0] BID_NARROW0 = 12'h178;
  localparam logic [ID_W-1:0] BID_NARROW1 = 12'h182;

  typedef enum logic [1:0] {
    VC_MUXED  = 2'd0,
    VC_PLAIN  = 2'd1,
    VC_NARROW = 2'd2,
    VC_ABSENT = 2'd3
  } variant_e;

endpackage

// File: rtl/disp_variant_dec.sv
module disp_variant_dec
  import disp_card_pkg::*;
(
  input  logic [ID_W-1:0] board_id,
  output variant_e        cls_o,
  output logic            wp_high_o
);

  always_comb begin
    unique case (board_id)
      BID_MUXED:                cls_o = VC_MUXED;
      BID_PLAIN:                cls_o = VC_PLAIN;
      BID_NARROW0, BID_NARROW1: cls_o = VC_NARROW;
      default:                  cls_o = VC_ABSENT;
    endcase
  end

  assign wp_high_o = (board_id == BID_MUXED) || (board_id == BID_PLAIN);

endmodule

// File: rtl/disp_ctrl_reg.sv
module disp_ctrl_reg
  import disp_card_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RO_LO      = 8,
  parameter int RO_HI      = 13,
  parameter int NARROW_BIT = 7,
  parameter int ID_LO      = 8,
  parameter int ID_RESET   = 31,
  parameter int MUX_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  variant_e          cls_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] disp_q_o,
  output logic [MUX_W-1:0]  mux_q_o
);

  localparam int RO_W = RO_HI - RO_LO + 1;
  localparam logic [DATA_W-1:0] RO_MASK   = DATA_W'(((64'd1 << RO_W) - 64'd1) << RO_LO);
  localparam logic [DATA_W-1:0] NB_MASK   = DATA_W'(64'd1 << NARROW_BIT);
  localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(64'(ID_RESET) << ID_LO);

  logic [DATA_W-1:0] disp_q, disp_d;
  logic [MUX_W-1:0]  mux_q, mux_d;
  logic              disp_en, mux_en;

  // next state
  always_comb begin
    disp_d  = disp_q;
    mux_d   = mux_q;
    disp_en = 1'b0;
    mux_en  = 1'b0;
    if (wr_en_i) begin
      case (cls_i)
        VC_MUXED: begin
          disp_en = 1'b1;
          disp_d  = (disp_q & RO_MASK) | (wdata_i & ~RO_MASK);
          mux_en  = 1'b1;
          mux_d   = wdata_i[MUX_W-1:0];
        end
        VC_PLAIN: begin
          disp_en = 1'b1;
          disp_d  = (disp_q & RO_MASK) | (wdata_i & ~RO_MASK);
        end
        VC_NARROW: begin
          disp_en = 1'b1;
          disp_d  = (disp_q & ~NB_MASK) | (wdata_i & NB_MASK);
        end
        default: begin
          disp_en = 1'b0;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= RESET_VAL;
    end else if (disp_en) begin
      disp_q <= disp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q <= '0;
    end else if (mux_en) begin
      mux_q <= mux_d;
    end
  end

  assign disp_q_o = disp_q;
  assign mux_q_o  = mux_q;

  p_ro_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (cls_i == VC_MUXED || cls_i == VC_PLAIN))
      |=> ((disp_q_o & RO_MASK) == ($past(disp_q_o) & RO_MASK)));

  p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (cls_i == VC_MUXED || cls_i == VC_PLAIN))
      |=> ((disp_q_o & ~RO_MASK) == ($past(wdata_i) & ~RO_MASK)));

  p_mux_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && cls_i == VC_MUXED) |=> (mux_q_o == $past(wdata_i[MUX_W-1:0])));

  p_mux_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && cls_i == VC_MUXED) |=> $stable(mux_q_o));

  p_narrow_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && cls_i == VC_NARROW)
      |=> (((disp_q_o & ~NB_MASK) == ($past(disp_q_o) & ~NB_MASK))
           && (disp_q_o[NARROW_BIT] == $past(wdata_i[NARROW_BIT]))));

endmodule

// File: rtl/card_status_sync.sv
module card_status_sync #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_present_i,
  input  logic              wprot_i,
  input  logic              wp_high_i,
  output logic [DATA_W-1:0] status_o
);

  logic [STAGES-1:0] cp_q, wp_q;
  logic              cp_s, wp_s;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cp_q <= '0;
          wp_q <= '0;
        end else begin
          cp_q <= {cp_q[STAGES-2:0], card_present_i};
          wp_q <= {wp_q[STAGES-2:0], wprot_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cp_q <= '0;
          wp_q <= '0;
        end else begin
          cp_q <= card_present_i;
          wp_q <= wprot_i;
        end
      end
    end
  endgenerate

  assign cp_s = cp_q[STAGES-1];
  assign wp_s = wp_q[STAGES-1];

  always_comb begin
    status_o    = '0;
    status_o[0] = cp_s;
    if (wp_high_i) status_o[2] = wp_s;
    else           status_o[1] = wp_s;
  end

  p_status_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[DATA_W-1:3] == '0) && (wp_high_i ? !status_o[1] : !status_o[2]));

endmodule

// File: rtl/disp_card_regs.sv
module disp_card_regs
  import disp_card_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          SYNC_STG = 2,
  parameter logic [11:0] DISP_OFF = 12'h050,
  parameter logic [11:0] CARD_OFF = 12'h048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   board_id,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              card_present_i,
  input  logic              wprot_i,
  output logic [1:0]        fmt_mux_o
);

  localparam logic [ADDR_W-1:0] A_DISP = ADDR_W'(DISP_OFF);
  localparam logic [ADDR_W-1:0] A_CARD = ADDR_W'(CARD_OFF);

  variant_e          cls;
  logic              wp_high;
  logic              wr_disp, wr_card;
  logic [DATA_W-1:0] disp_q, status;

  assign wr_disp = bus_sel && bus_wr && (bus_addr == A_DISP);
  assign wr_card = bus_sel && bus_wr && (bus_addr == A_CARD);

  disp_variant_dec u_dec (
    .board_id  (board_id),
    .cls_o     (cls),
    .wp_high_o (wp_high)
  );

  disp_ctrl_reg #(
    .DATA_W (DATA_W),
    .MUX_W  (2)
  ) u_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cls_i    (cls),
    .wr_en_i  (wr_disp),
    .wdata_i  (bus_wdata),
    .disp_q_o (disp_q),
    .mux_q_o  (fmt_mux_o)
  );

  card_status_sync #(
    .DATA_W (DATA_W),
    .STAGES (SYNC_STG)
  ) u_card (
    .clk            (clk),
    .rst_n          (rst_n),
    .card_present_i (card_present_i),
    .wprot_i        (wprot_i),
    .wp_high_i      (wp_high),
    .status_o       (status)
  );

  always_comb begin
    if (bus_addr == A_DISP)      bus_rdata = (cls == VC_ABSENT) ? '0 : disp_q;
    else if (bus_addr == A_CARD) bus_rdata = status;
    else                         bus_rdata = '0;
  end

  p_absent_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == VC_ABSENT && bus_addr == A_DISP) |-> (bus_rdata == '0));

  p_card_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_card |=> ($stable(disp_q) && $stable(fmt_mux_o)));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != A_DISP && bus_addr != A_CARD) |-> (bus_rdata == '0));

endmodule

// File: tb/disp_card_regs_tb_top.sv
`timescale 1ns/1ps
module disp_card_regs_tb_top;

  localparam real HALF = 2.5;
  localparam logic [11:0] A_DISP = 12'h050;
  localparam logic [11:0] A_CARD = 12'h048;
  localparam logic [11:0] A_FREE = 12'h04C;

  typedef struct packed {
    logic [11:0] bid;
    logic [31:0] wd;
    logic [31:0] ed;
    logic [1:0]  em;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{12'h100, 32'hFFFFFFFF, 32'hFFFFDFFF, 2'd3, 4'd2},
    '{12'h100, 32'h00000002, 32'h00001F02, 2'd2, 4'd2},
    '{12'h100, 32'h12345601, 32'h12345F01, 2'd1, 4'd2},
    '{12'h140, 32'hFFFFFFFF, 32'hFFFFDFFF, 2'd0, 4'd4},
    '{12'h140, 32'h0000C0A3, 32'h0000DFA3, 2'd0, 4'd4},
    '{12'h178, 32'hFFFFFFFF, 32'h00001F80, 2'd0, 4'd5},
    '{12'h178, 32'h00000000, 32'h00001F00, 2'd0, 4'd5},
    '{12'h178, 32'h00000080, 32'h00001F80, 2'd0, 4'd5},
    '{12'h182, 32'hFFFFFF7F, 32'h00001F00, 2'd0, 4'd5},
    '{12'h182, 32'h00000080, 32'h00001F80, 2'd0, 4'd5},
    '{12'h190, 32'hFFFFFFFF, 32'h00000000, 2'd0, 4'd6},
    '{12'h000, 32'h12345678, 32'h00000000, 2'd0, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] board_id = 12'h100;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        card_present_i = 1'b0;
  logic        wprot_i = 1'b0;
  logic [1:0]  fmt_mux_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  disp_card_regs dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .board_id       (board_id),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .card_present_i (card_present_i),
    .wprot_i        (wprot_i),
    .fmt_mux_o      (fmt_mux_o)
  );

  function automatic string rname(int n);
    case (n)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(logic [11:0] bid);
    @(negedge clk);
    rst_n    = 1'b0;
    board_id = bid;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [11:0] cur;

    // R1 reset state
    do_reset(12'h100);
    rd(A_DISP, r);  chk("R1", "disp reset 0x100", r, 32'h00001F00);
    chk("R1", "mux reset", {30'd0, fmt_mux_o}, 32'd0);
    rd(A_CARD, r);  chk("R1", "card reset", r, 32'd0);
    do_reset(12'h178);
    rd(A_DISP, r);  chk("R1", "disp reset 0x178", r, 32'h00001F00);
    do_reset(12'h190);
    rd(A_DISP, r);  chk("R6", "disp reset 0x190", r, 32'd0);

    // table walk
    cur = 12'hFFF;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].bid != cur) begin
        do_reset(VECS[i].bid);
        cur = VECS[i].bid;
      end
      wr(A_DISP, VECS[i].wd);
      rd(A_DISP, r);
      chk(rname(int'(VECS[i].rq)), "disp after write", r, VECS[i].ed);
      chk(cur == 12'h100 ? "R3" : (cur == 12'h140 ? "R4" : rname(int'(VECS[i].rq))),
          "mux after write", {30'd0, fmt_mux_o}, {30'd0, VECS[i].em});
    end

    // R3, R9, R10: holding across other writes
    do_reset(12'h100);
    wr(A_DISP, 32'h00000003);
    wr(A_CARD, 32'hFFFFFFFF);
    chk("R3", "mux held over card write", {30'd0, fmt_mux_o}, 32'd3);
    rd(A_CARD, r);  chk("R9", "card after write", r, 32'd0);
    rd(A_DISP, r);  chk("R9", "disp after card write", r, 32'h00001F03);
    wr(A_FREE, 32'h00000000);
    rd(A_DISP, r);  chk("R10", "disp after free write", r, 32'h00001F03);
    chk("R10", "mux after free write", {30'd0, fmt_mux_o}, 32'd3);
    rd(A_FREE, r);  chk("R10", "free offset read", r, 32'd0);

    // R7 synchroniser depth
    @(negedge clk);
    card_present_i = 1'b1;
    @(negedge clk);
    bus_addr = A_CARD;
    #1 chk("R7", "card one edge", bus_rdata, 32'd0);
    @(negedge clk);
    #1 chk("R7", "card two edges", bus_rdata, 32'd1);

    // R8 write-protect placement
    @(negedge clk);
    wprot_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(A_CARD, r);  chk("R8", "wp at bit2 on 0x100", r, 32'h5);
    do_reset(12'h182);
    @(negedge clk);
    @(negedge clk);
    rd(A_CARD, r);  chk("R8", "wp at bit1 on 0x182", r, 32'h3);
    do_reset(12'h140);
    @(negedge clk);
    @(negedge clk);
    rd(A_CARD, r);  chk("R8", "wp at bit2 on 0x140", r, 32'h5);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule